// File: doc/BRIEF.md
# Binary Tree Routing Node

This block is one interior switch of a complete binary routing tree. It links one parent port and two child ports, and each link carries traffic in both directions under a valid/ready handshake. A packet coming down from the parent leaves on one child. The node picks that child from a single destination bit tied to its level in the tree, so it never has to arbitrate on the way down. Packets coming up from the two children compete for the one parent link. A round-robin arbiter merges them.

Marker packets divide one simulation step from the next. A marker coming down is copied to both children. Going up, a marker waits at the head of its child's queue. The node sends one marker to the parent only when both children have a marker at their heads. This holds back anything that entered behind a marker, so traffic from the next step cannot pass it. The end-of-stream and end-of-replies markers follow this same rule.

Each edge that the node owns has its own queue: one toward each child, and one from each child. A full queue pushes back through ready. No packet is ever dropped.

Packets are `{kind[1:0], dest[DEST_W-1:0], src[SRC_W-1:0], payload[PAY_W-1:0]}`. The kind codes are 0 = read, 1 = write or reply, 2 = marker.

Top module: `tree_route_node`

## Requirements
- R1: After reset, `parentUpValid`, `leftDownValid` and `rightDownValid` are 0, and `leftUpReady`, `rightUpReady` and `parentDownReady` are 1.
- R2: A downward packet of kind 0 or 1 is delivered to exactly one child. When dest bit `LEVEL` (packet bit `PAY_W+SRC_W+LEVEL`) is 1 it goes to the right child, otherwise to the left. Packets to each child keep their arrival order.
- R3: A downward marker (kind 2, packet bits `[PKT_W-1:PKT_W-2]`) is copied to both children. It is accepted only when both downward queues have space.
- R4: Each downward queue holds `DEPTH` packets. When the queue for the addressed child is full, `parentDownReady` is 0 and no packet is lost. A child output that is not accepted holds its data, and traffic to the other child keeps flowing.
- R5: Upward packets reach the parent in the order in which each child sent them. A parent output that is not accepted holds its data.
- R6: When both children have ordinary packets waiting, the parent output alternates between them.
- R7: A marker at the head of one child's upward queue is sent only once the other child's queue also has a marker at its head. The node then sends one marker, which carries the left child's fields, and removes both markers in the same handshake.
- R8: Packets that a child sends after its marker are not forwarded until the markers have combined. Ordinary packets from the other child that arrived before its own marker still pass.
- R9: Each upward queue holds `DEPTH` packets. When it is full, that child's ready is 0, while the other child's ready is unaffected.
- R10: A downward accept and an upward send can happen in the same cycle, including a marker in each direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parentDownValid | input | 1 | Packet offered from the parent |
| parentDownReady | output | 1 | Node can take the offered packet |
| parentDownData | input | PKT_W | Packet from the parent |
| leftDownValid | output | 1 | Packet offered to the left child |
| leftDownReady | input | 1 | Left child takes it |
| leftDownData | output | PKT_W | Packet to the left child |
| rightDownValid | output | 1 | Packet offered to the right child |
| rightDownReady | input | 1 | Right child takes it |
| rightDownData | output | PKT_W | Packet to the right child |
| leftUpValid | input | 1 | Packet offered by the left child |
| leftUpReady | output | 1 | Node can take the left child's packet |
| leftUpData | input | PKT_W | Packet from the left child |
| rightUpValid | input | 1 | Packet offered by the right child |
| rightUpReady | output | 1 | Node can take the right child's packet |
| rightUpData | input | PKT_W | Packet from the right child |
| parentUpValid | output | 1 | Packet offered to the parent |
| parentUpReady | input | 1 | Parent takes it |
| parentUpData | output | PKT_W | Packet to the parent |

## Verification
The two functions that collide are the downward broadcast of a marker and the upward combining of a marker pair. The bench provokes the collision by stalling the parent until both children's markers sit at their queue heads. It then releases the parent and offers a downward marker in the same cycle. A counter in the monitor records whether both handshakes happened in one cycle. The scoreboards confirm that each child received the copied marker and that the parent received exactly one combined marker carrying the left child's fields.

// File: rtl/tree_node_pkg.sv
package tree_node_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_MARK  = 2'd2
  } pktKind_e;

  // strobes from control to datapath; index 0 = left child, 1 = right child
  typedef struct packed {
    logic [1:0] pushDown;
    logic [1:0] pushUp;
    logic [1:0] popUp;
    logic       upSelRight;
    logic       upValid;
  } nodeCtl_t;

endpackage

// File: rtl/node_fifo.sv
module node_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign notEmpty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/node_datapath.sv
module node_datapath
  import tree_node_pkg::*;
#(
  parameter int PKT_W = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  nodeCtl_t         ctl,
  input  logic [PKT_W-1:0] parentDownData,
  input  logic [PKT_W-1:0] leftUpData,
  input  logic [PKT_W-1:0] rightUpData,
  input  logic [1:0]       childDownReady,
  output logic [1:0]       childDownValid,
  output logic [PKT_W-1:0] leftDownData,
  output logic [PKT_W-1:0] rightDownData,
  output logic [PKT_W-1:0] parentUpData,
  output logic [1:0]       downFull,
  output logic [1:0]       upFull,
  output logic [1:0]       upNotEmpty,
  output logic [1:0][1:0]  upHeadKind
);
  logic [PKT_W-1:0] upIn     [2];
  logic [PKT_W-1:0] downHead [2];
  logic [PKT_W-1:0] upHead   [2];

  assign upIn[0] = leftUpData;
  assign upIn[1] = rightUpData;

  for (genvar c = 0; c < 2; c++) begin : gChild
    node_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH)) downQ (
      .clk      (clk),
      .rstN     (rstN),
      .push     (ctl.pushDown[c]),
      .pushData (parentDownData),
      .pop      (childDownValid[c] && childDownReady[c]),
      .headData (downHead[c]),
      .notEmpty (childDownValid[c]),
      .full     (downFull[c])
    );
    node_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH)) upQ (
      .clk      (clk),
      .rstN     (rstN),
      .push     (ctl.pushUp[c]),
      .pushData (upIn[c]),
      .pop      (ctl.popUp[c]),
      .headData (upHead[c]),
      .notEmpty (upNotEmpty[c]),
      .full     (upFull[c])
    );
    assign upHeadKind[c] = upHead[c][PKT_W-1 -: 2];
  end

  assign leftDownData  = downHead[0];
  assign rightDownData = downHead[1];
  // a combined marker carries the left head
  assign parentUpData  = ctl.upSelRight ? upHead[1] : upHead[0];
endmodule

// File: rtl/node_control.sv
module node_control
  import tree_node_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            parentDownValid,
  input  logic [1:0]      downKind,
  input  logic            downDestBit,
  input  logic [1:0]      downFull,
  input  logic [1:0]      childUpValid,
  input  logic [1:0]      upFull,
  input  logic [1:0]      upNotEmpty,
  input  logic [1:0][1:0] upHeadKind,
  input  logic            parentUpReady,
  output nodeCtl_t        ctl,
  output logic            parentDownReady,
  output logic [1:0]      childUpReady
);
  logic       downIsMark;
  logic [1:0] ordHead, markHead;
  logic       pair, show, selRight, fire;
  logic       lockValid, lockRight, favorRight;

  always_comb begin
    ctl = '0;
    // downward steering
    downIsMark = (downKind == KIND_MARK);
    if (downIsMark) parentDownReady = !downFull[0] && !downFull[1];
    else            parentDownReady = downDestBit ? !downFull[1] : !downFull[0];
    if (parentDownValid && parentDownReady) begin
      ctl.pushDown[0] = downIsMark || !downDestBit;
      ctl.pushDown[1] = downIsMark || downDestBit;
    end
    // upward intake
    childUpReady = ~upFull;
    ctl.pushUp   = childUpValid & ~upFull;
    // upward arbitration
    for (int c = 0; c < 2; c++) begin
      markHead[c] = upNotEmpty[c] && (upHeadKind[c] == KIND_MARK);
      ordHead[c]  = upNotEmpty[c] && (upHeadKind[c] != KIND_MARK);
    end
    pair     = markHead[0] && markHead[1];
    show     = 1'b0;
    selRight = 1'b0;
    if (lockValid) begin
      show     = 1'b1;
      selRight = lockRight;
    end else if (pair) begin
      show = 1'b1;
    end else if (ordHead[0] && ordHead[1]) begin
      show     = 1'b1;
      selRight = favorRight;
    end else if (ordHead[1]) begin
      show     = 1'b1;
      selRight = 1'b1;
    end else if (ordHead[0]) begin
      show = 1'b1;
    end
    fire           = show && parentUpReady;
    ctl.upValid    = show;
    ctl.upSelRight = selRight;
    ctl.popUp[0]   = fire && (pair || !selRight);
    ctl.popUp[1]   = fire && (pair || selRight);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockValid  <= 1'b0;
      lockRight  <= 1'b0;
      favorRight <= 1'b0;
    end else begin
      lockValid <= show && !parentUpReady && !pair;
      lockRight <= selRight;
      if (fire && !pair) favorRight <= !selRight;
    end
  end
endmodule

// File: rtl/tree_route_node.sv
module tree_route_node
  import tree_node_pkg::*;
#(
  parameter int DEST_W = 4,
  parameter int SRC_W  = 4,
  parameter int PAY_W  = 8,
  parameter int LEVEL  = 1,
  parameter int DEPTH  = 4,
  localparam int PKT_W = 2 + DEST_W + SRC_W + PAY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             parentDownValid,
  output logic             parentDownReady,
  input  logic [PKT_W-1:0] parentDownData,
  output logic             leftDownValid,
  input  logic             leftDownReady,
  output logic [PKT_W-1:0] leftDownData,
  output logic             rightDownValid,
  input  logic             rightDownReady,
  output logic [PKT_W-1:0] rightDownData,
  input  logic             leftUpValid,
  output logic             leftUpReady,
  input  logic [PKT_W-1:0] leftUpData,
  input  logic             rightUpValid,
  output logic             rightUpReady,
  input  logic [PKT_W-1:0] rightUpData,
  output logic             parentUpValid,
  input  logic             parentUpReady,
  output logic [PKT_W-1:0] parentUpData
);
  localparam int DEST_BIT = PAY_W + SRC_W + LEVEL;

  nodeCtl_t       ctl;
  logic [1:0]     downFull, upFull, upNotEmpty, childDownValid, childUpReady;
  logic [1:0][1:0] upHeadKind;

  node_control u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .parentDownValid (parentDownValid),
    .downKind        (parentDownData[PKT_W-1 -: 2]),
    .downDestBit     (parentDownData[DEST_BIT]),
    .downFull        (downFull),
    .childUpValid    ({rightUpValid, leftUpValid}),
    .upFull          (upFull),
    .upNotEmpty      (upNotEmpty),
    .upHeadKind      (upHeadKind),
    .parentUpReady   (parentUpReady),
    .ctl             (ctl),
    .parentDownReady (parentDownReady),
    .childUpReady    (childUpReady)
  );

  node_datapath #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .parentDownData (parentDownData),
    .leftUpData     (leftUpData),
    .rightUpData    (rightUpData),
    .childDownReady ({rightDownReady, leftDownReady}),
    .childDownValid (childDownValid),
    .leftDownData   (leftDownData),
    .rightDownData  (rightDownData),
    .parentUpData   (parentUpData),
    .downFull       (downFull),
    .upFull         (upFull),
    .upNotEmpty     (upNotEmpty),
    .upHeadKind     (upHeadKind)
  );

  assign leftDownValid  = childDownValid[0];
  assign rightDownValid = childDownValid[1];
  assign leftUpReady    = childUpReady[0];
  assign rightUpReady   = childUpReady[1];
  assign parentUpValid  = ctl.upValid;
endmodule

// File: rtl/tree_route_node_chk.sv
module tree_route_node_chk #(
  parameter int PKT_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             parentDownValid,
  input logic             parentDownReady,
  input logic [PKT_W-1:0] parentDownData,
  input logic             leftDownValid,
  input logic             leftDownReady,
  input logic [PKT_W-1:0] leftDownData,
  input logic             rightDownValid,
  input logic             rightDownReady,
  input logic [PKT_W-1:0] rightDownData,
  input logic             leftUpValid,
  input logic             leftUpReady,
  input logic [PKT_W-1:0] leftUpData,
  input logic             rightUpValid,
  input logic             rightUpReady,
  input logic [PKT_W-1:0] rightUpData,
  input logic             parentUpValid,
  input logic             parentUpReady,
  input logic [PKT_W-1:0] parentUpData
);
  logic [7:0] pendLeft, pendRight;
  logic inLeftMark, inRightMark, outMark, upIsMark;

  assign upIsMark    = parentUpData[PKT_W-1 -: 2] == 2'd2;
  assign inLeftMark  = leftUpValid && leftUpReady && leftUpData[PKT_W-1 -: 2] == 2'd2;
  assign inRightMark = rightUpValid && rightUpReady && rightUpData[PKT_W-1 -: 2] == 2'd2;
  assign outMark     = parentUpValid && parentUpReady && upIsMark;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLeft  <= '0;
      pendRight <= '0;
    end else begin
      pendLeft  <= pendLeft + 8'(inLeftMark) - 8'(outMark);
      pendRight <= pendRight + 8'(inRightMark) - 8'(outMark);
    end
  end

  assert_marker_pair_R7: assert property (@(posedge clk) disable iff (!rstN)
    (parentUpValid && upIsMark) |-> (pendLeft != 0 && pendRight != 0));

  assert_down_broadcast_R3: assert property (@(posedge clk) disable iff (!rstN)
    (parentDownValid && parentDownReady && parentDownData[PKT_W-1 -: 2] == 2'd2)
      |=> (leftDownValid && rightDownValid));

  assert_left_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (leftDownValid && !leftDownReady) |=> (leftDownValid && $stable(leftDownData)));

  assert_right_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rightDownValid && !rightDownReady) |=> (rightDownValid && $stable(rightDownData)));

  assert_up_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parentUpValid && !parentUpReady) |=> (parentUpValid && $stable(parentUpData)));
endmodule

bind tree_route_node tree_route_node_chk #(.PKT_W(PKT_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .parentDownValid(parentDownValid), .parentDownReady(parentDownReady), .parentDownData(parentDownData),
  .leftDownValid(leftDownValid), .leftDownReady(leftDownReady), .leftDownData(leftDownData),
  .rightDownValid(rightDownValid), .rightDownReady(rightDownReady), .rightDownData(rightDownData),
  .leftUpValid(leftUpValid), .leftUpReady(leftUpReady), .leftUpData(leftUpData),
  .rightUpValid(rightUpValid), .rightUpReady(rightUpReady), .rightUpData(rightUpData),
  .parentUpValid(parentUpValid), .parentUpReady(parentUpReady), .parentUpData(parentUpData)
);

// File: tb/tb_tree_route_node.sv
module tb_tree_route_node;
  localparam int CLK_PERIOD = 10;
  localparam int PKT_W = 18;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parentDownValid = 1'b0, parentDownReady;
  logic [PKT_W-1:0] parentDownData = '0;
  logic leftDownValid, rightDownValid;
  logic leftDownReady = 1'b1, rightDownReady = 1'b1;
  logic [PKT_W-1:0] leftDownData, rightDownData;
  logic leftUpValid = 1'b0, rightUpValid = 1'b0, leftUpReady, rightUpReady;
  logic [PKT_W-1:0] leftUpData = '0, rightUpData = '0;
  logic parentUpValid, parentUpReady = 1'b1;
  logic [PKT_W-1:0] parentUpData;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_route_node dut (
    .clk(clk), .rstN(rstN),
    .parentDownValid(parentDownValid), .parentDownReady(parentDownReady), .parentDownData(parentDownData),
    .leftDownValid(leftDownValid), .leftDownReady(leftDownReady), .leftDownData(leftDownData),
    .rightDownValid(rightDownValid), .rightDownReady(rightDownReady), .rightDownData(rightDownData),
    .leftUpValid(leftUpValid), .leftUpReady(leftUpReady), .leftUpData(leftUpData),
    .rightUpValid(rightUpValid), .rightUpReady(rightUpReady), .rightUpData(rightUpData),
    .parentUpValid(parentUpValid), .parentUpReady(parentUpReady), .parentUpData(parentUpData)
  );

  int nChecks = 0;
  int nFail = 0;
  int concurrent = 0;
  logic [PKT_W-1:0] expDL[$], expDR[$], expUL[$], expUR[$];
  int srcLog[$];

  // packet layout: kind[17:16] dest[15:12] src[11:8] payload[7:0]
  function automatic logic [PKT_W-1:0] mk(input logic [1:0] k, input logic [3:0] d,
                                          input logic [3:0] s, input logic [7:0] p);
    return {k, d, s, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sendDown(input logic [PKT_W-1:0] p);
    @(posedge clk); #1;
    parentDownValid = 1'b1;
    parentDownData  = p;
    forever begin
      @(negedge clk);
      if (parentDownReady) break;
    end
    if (p[17:16] == 2'd2) begin
      expDL.push_back(p);
      expDR.push_back(p);
    end else if (p[13]) expDR.push_back(p);
    else expDL.push_back(p);
    @(posedge clk); #1;
    parentDownValid = 1'b0;
  endtask

  task automatic sendUp(input int side, input logic [PKT_W-1:0] p);
    @(posedge clk); #1;
    if (side == 0) begin leftUpValid = 1'b1; leftUpData = p; end
    else begin rightUpValid = 1'b1; rightUpData = p; end
    forever begin
      @(negedge clk);
      if ((side == 0) ? leftUpReady : rightUpReady) break;
    end
    if (side == 0) expUL.push_back(p); else expUR.push_back(p);
    @(posedge clk); #1;
    if (side == 0) leftUpValid = 1'b0; else rightUpValid = 1'b0;
  endtask

  // down monitors (R2, R3, R4)
  always @(negedge clk) if (rstN) begin
    if (leftDownValid && leftDownReady) begin
      if (expDL.size() == 0) check(0, "R2 unexpected left packet", 32'(leftDownData), 0);
      else begin
        check(leftDownData == expDL[0], "R2 left order/data", 32'(leftDownData), 32'(expDL[0]));
        void'(expDL.pop_front());
      end
    end
    if (rightDownValid && rightDownReady) begin
      if (expDR.size() == 0) check(0, "R2 unexpected right packet", 32'(rightDownData), 0);
      else begin
        check(rightDownData == expDR[0], "R2 right order/data", 32'(rightDownData), 32'(expDR[0]));
        void'(expDR.pop_front());
      end
    end
  end

  // up monitor (R5, R7, R8) and collision counter (R10)
  always @(negedge clk) if (rstN) begin
    if (parentUpValid && parentUpReady) begin
      if (parentUpData[17:16] == 2'd2) begin
        srcLog.push_back(2);
        if (expUL.size() > 0 && expUR.size() > 0 && expUL[0][17:16] == 2'd2 && expUR[0][17:16] == 2'd2) begin
          check(parentUpData == expUL[0], "R7 combined marker fields", 32'(parentUpData), 32'(expUL[0]));
          void'(expUL.pop_front());
          void'(expUR.pop_front());
        end else check(0, "R7 marker without pair", 32'(parentUpData), 0);
      end else if (parentUpData[8] == 1'b0) begin
        srcLog.push_back(0);
        if (expUL.size() == 0) check(0, "R5 unexpected left-origin packet", 32'(parentUpData), 0);
        else begin
          check(parentUpData == expUL[0], "R5/R8 left order", 32'(parentUpData), 32'(expUL[0]));
          void'(expUL.pop_front());
        end
      end else begin
        srcLog.push_back(1);
        if (expUR.size() == 0) check(0, "R5 unexpected right-origin packet", 32'(parentUpData), 0);
        else begin
          check(parentUpData == expUR[0], "R5/R8 right order", 32'(parentUpData), 32'(expUR[0]));
          void'(expUR.pop_front());
        end
      end
      if (parentDownValid && parentDownReady && parentDownData[17:16] == 2'd2 &&
          parentUpData[17:16] == 2'd2) concurrent++;
    end
  end

  initial begin
    waitCycles(20000);
    check(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    waitCycles(3);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(!parentUpValid, "R1 parentUpValid", 32'(parentUpValid), 0);
    check(!leftDownValid && !rightDownValid, "R1 child down valid", 32'({leftDownValid, rightDownValid}), 0);
    check(leftUpReady && rightUpReady, "R1 child up ready", 32'({leftUpReady, rightUpReady}), 3);
    check(parentDownReady, "R1 parentDownReady", 32'(parentDownReady), 1);

    // R2 steering by dest bit 1
    for (int i = 0; i < 8; i++) sendDown(mk(2'(i % 2), 4'(i), 4'h0, 8'h10 + 8'(i)));
    waitCycles(4);
    check(expDL.size() == 0 && expDR.size() == 0, "R2 all delivered", 32'(expDL.size() + expDR.size()), 0);

    // R3 marker broadcast
    sendDown(mk(2'd2, 4'h0, 4'h0, 8'h01));
    waitCycles(4);
    check(expDL.size() == 0 && expDR.size() == 0, "R3 marker to both children", 32'(expDL.size() + expDR.size()), 0);

    // R4 backpressure on left child
    @(posedge clk); #1 leftDownReady = 1'b0;
    for (int i = 0; i < DEPTH; i++) sendDown(mk(2'd0, 4'h0, 4'h0, 8'h40 + 8'(i)));
    @(posedge clk); #1 parentDownData = mk(2'd0, 4'h1, 4'h0, 8'h4f);
    @(negedge clk);
    check(!parentDownReady, "R4 ready low when left full", 32'(parentDownReady), 0);
    @(posedge clk); #1 parentDownData = mk(2'd0, 4'h2, 4'h0, 8'h4e);
    @(negedge clk);
    check(parentDownReady, "R4 right path open", 32'(parentDownReady), 1);
    @(posedge clk); #1 parentDownData = mk(2'd2, 4'h0, 4'h0, 8'h4d);
    @(negedge clk);
    check(!parentDownReady, "R3 marker needs both spaces", 32'(parentDownReady), 0);
    sendDown(mk(2'd1, 4'h2, 4'h0, 8'h4c));
    fork
      sendDown(mk(2'd0, 4'h0, 4'h0, 8'h44));
      begin waitCycles(5); #1 leftDownReady = 1'b1; end
    join
    waitCycles(8);
    check(expDL.size() == 0 && expDR.size() == 0, "R4 no packet lost", 32'(expDL.size() + expDR.size()), 0);

    // R5 merge from both children
    fork
      for (int i = 0; i < 5; i++) sendUp(0, mk(2'd1, 4'h0, 4'h0, 8'h20 + 8'(i)));
      for (int i = 0; i < 5; i++) sendUp(1, mk(2'd1, 4'h0, 4'h1, 8'h28 + 8'(i)));
    join
    waitCycles(6);
    check(expUL.size() == 0 && expUR.size() == 0, "R5 all merged", 32'(expUL.size() + expUR.size()), 0);

    // R6 round robin under contention
    @(posedge clk); #1 parentUpReady = 1'b0;
    srcLog.delete();
    fork
      for (int i = 0; i < 3; i++) sendUp(0, mk(2'd0, 4'h0, 4'h0, 8'h50 + 8'(i)));
      for (int i = 0; i < 3; i++) sendUp(1, mk(2'd0, 4'h0, 4'h1, 8'h58 + 8'(i)));
    join
    @(posedge clk); #1 parentUpReady = 1'b1;
    waitCycles(10);
    check(srcLog.size() == 6, "R6 count", 32'(srcLog.size()), 6);
    for (int k = 1; k < srcLog.size(); k++)
      check(srcLog[k] != srcLog[k-1], "R6 alternation", 32'(srcLog[k]), 32'(1 - srcLog[k-1]));

    // R9 up queue full
    @(posedge clk); #1 parentUpReady = 1'b0;
    for (int i = 0; i < DEPTH; i++) sendUp(0, mk(2'd1, 4'h0, 4'h0, 8'h60 + 8'(i)));
    @(negedge clk);
    check(!leftUpReady, "R9 left ready low when full", 32'(leftUpReady), 0);
    check(rightUpReady, "R9 right ready unaffected", 32'(rightUpReady), 1);
    fork
      sendUp(0, mk(2'd1, 4'h0, 4'h0, 8'h6f));
      begin waitCycles(4); #1 parentUpReady = 1'b1; end
    join
    waitCycles(10);
    check(expUL.size() == 0, "R9 no packet lost", 32'(expUL.size()), 0);

    // R7 / R8 marker combine
    sendUp(0, mk(2'd2, 4'h0, 4'h0, 8'h05));
    sendUp(0, mk(2'd1, 4'h0, 4'h0, 8'h30));
    sendUp(1, mk(2'd1, 4'h0, 4'h1, 8'h31));
    waitCycles(6);
    @(negedge clk);
    check(!parentUpValid, "R8 held behind lone marker", 32'(parentUpValid), 0);
    check(expUL.size() == 2, "R8 left marker and follower pending", 32'(expUL.size()), 2);
    check(expUR.size() == 0, "R8 right packet before marker passed", 32'(expUR.size()), 0);
    sendUp(1, mk(2'd2, 4'h0, 4'h1, 8'h06));
    waitCycles(6);
    check(expUL.size() == 0 && expUR.size() == 0, "R7 pair combined then follower sent",
          32'(expUL.size() + expUR.size()), 0);

    // R10 marker down and marker pair up in the same cycle
    @(posedge clk); #1 parentUpReady = 1'b0;
    fork
      sendUp(0, mk(2'd2, 4'h0, 4'h0, 8'h07));
      sendUp(1, mk(2'd2, 4'h0, 4'h1, 8'h08));
    join
    concurrent = 0;
    @(posedge clk); #1;
    parentUpReady   = 1'b1;
    parentDownValid = 1'b1;
    parentDownData  = mk(2'd2, 4'h0, 4'h0, 8'h09);
    expDL.push_back(parentDownData);
    expDR.push_back(parentDownData);
    @(negedge clk);
    check(parentDownReady && parentUpValid, "R10 both handshakes ready", 32'({parentDownReady, parentUpValid}), 3);
    @(posedge clk); #1 parentDownValid = 1'b0;
    waitCycles(5);
    check(concurrent == 1, "R10 same-cycle marker traffic", 32'(concurrent), 1);
    check(expDL.size() + expDR.size() + expUL.size() + expUR.size() == 0, "R10 scoreboards drained",
          32'(expDL.size() + expDR.size() + expUL.size() + expUR.size()), 0);

    summary();
    $finish;
  end
endmodule